// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block sends one byte from a pointing device to its host over the two-wire PS/2 bus. The device supplies the bus clock. Internal logic hands over a byte with a single-cycle request, and the block keeps it in a one-entry holding register. The block starts a frame only when both bus lines read high. It drives the open-drain lines through pull-low enables and watches the sampled clock line for a host that takes the bus back in the middle of a frame.

Each bit of a frame lasts four quarter periods, and each quarter period is `QTR_CYC` system cycles long. The clock line is released for the first two quarters and pulled low for the last two. DATA moves one quarter after the clock is released. This gives a quarter of hold time after each rising edge and a quarter of setup time before each falling edge. The block samples the clock line once per bit, at the end of its released half. If the host holds the clock low before the tenth rising edge, the block releases both lines, keeps the byte and raises `retry_pending`. It resends the byte by itself once the bus is idle again. If contention comes later than that edge, the frame runs to its end.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset, both pull-low enables are off and `tx_done` and `retry_pending` are low.
- R2: While the synchronised CLK line reads low, no frame starts. A request accepted during this wait replaces the held byte, and only the latest byte is sent.
- R3: While CLK reads high and DATA reads low (host wants to send), no frame starts.
- R4: A frame begins only after both synchronised lines have read high.
- R5: A frame has exactly 11 clock pulses. The bits are a start bit of 0, the eight data bits least significant first, an odd parity bit, and a stop bit of 1. A 0 is sent by pulling DATA low and a 1 by releasing it. The bit value is taken at each falling edge of CLK.
- R6: Within a frame, CLK is pulled low for 2·`QTR_CYC` cycles per pulse and released for 2·`QTR_CYC` cycles between pulses. DATA changes only while CLK is released: exactly `QTR_CYC` cycles after the rising edge, and never while CLK is pulled low.
- R7: If CLK reads low at the end of the released half of bits 0 to 9, the block releases both lines on the next cycle and sets `retry_pending`.
- R8: After an abort, the same byte is resent once the bus is idle, and `retry_pending` returns low when that frame completes.
- R9: If CLK reads low during the released half of the stop bit (after the tenth rising edge), this has no effect. The frame completes and `tx_done` pulses.
- R10: `tx_done` is high for exactly one cycle, as CLK is released after the eleventh pulse. The held byte is then dropped, and no further frame starts without a new request.
- R11: A request made while a frame is in progress is ignored and does not change the byte being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_byte | input | 8 | Byte to send, taken when `tx_req` is high |
| tx_req | input | 1 | Single-cycle send request |
| ps2_clk_in | input | 1 | Sampled level of the bus CLK line |
| ps2_data_in | input | 1 | Sampled level of the bus DATA line |
| ps2_clk_pull | output | 1 | Pulls the CLK line low when high |
| ps2_data_pull | output | 1 | Pulls the DATA line low when high |
| tx_done | output | 1 | One-cycle pulse when a frame completes |
| retry_pending | output | 1 | Set by an aborted frame, cleared on the next completion |

## Verification
The bench builds the block with `QTR_CYC` = 8 and two synchroniser stages. A full frame then takes 352 cycles, so every test case fits easily in the run. At this size, the bench can place host contention at a chosen pulse: after the third pulse, at the parity bit (the last point where an abort still happens), and at the stop bit (where contention must be ignored). The short quarter also lets the bench check each pulse width and each DATA change against exact cycle counts.

// File: rtl/ps2tx_pkg.sv
// Shared constants and types for the PS/2 device-side transmitter.
// Assumes an 11-bit frame and one state register held in the top module.
package ps2tx_pkg;
    localparam int FRAME_LEN      = 11;
    localparam int LAST_ABORT_BIT = 9;
    localparam int BIT_W          = 4;

    typedef enum logic { ST_IDLE, ST_SEND } tx_state_t;

    // Quarter-period position inside one bit cell.
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW_A = 2'd2,
        PH_LOW_B = 2'd3
    } phase_t;
endpackage

// File: rtl/ps2tx_sync.sv
// Multi-stage synchroniser for the sampled bus lines.
// Assumes the bus idles high, so every stage resets to 1.
module ps2tx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage retimes the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ps2tx_qdiv.sv
// Quarter-period tick generator. It counts system cycles while run is high
// and emits one tick every QTR_CYC cycles. It restarts from zero whenever
// run is low. Assumes QTR_CYC >= 3 so the synchronised clock has settled
// before the contention sample.
module ps2tx_qdiv #(
    parameter int QTR_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(QTR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt;

    // Count up to the quarter boundary, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/ps2tx_framebits.sv
// Maps a bit index (0..10) of the frame to the line level for that bit:
// 0 for the start bit, data least significant first, odd parity, 1 for stop.
module ps2tx_framebits
    import ps2tx_pkg::*;
(
    input  logic [7:0]       dbyte,
    input  logic [BIT_W-1:0] idx,
    output logic             level
);
    logic [BIT_W-1:0] didx;

    // Pick the level for the current index.
    always_comb begin
        didx = idx - 4'd1;
        if (idx == 4'd0)      level = 1'b0;
        else if (idx <= 4'd8) level = dbyte[didx[2:0]];
        else if (idx == 4'd9) level = ~^dbyte;
        else                  level = 1'b1;
    end
endmodule

// File: rtl/ps2_dev_tx.sv
// Device-side PS/2 transmitter. It holds one byte, waits for an idle bus,
// then clocks out an 11-bit frame through pull-low enables. It aborts and
// keeps the byte if the host holds CLK low before the tenth rising edge.
// Assumes the line inputs may be asynchronous; they are synchronised here.
module ps2_dev_tx
    import ps2tx_pkg::*;
#(
    parameter int QTR_CYC     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_req,
    input  logic       ps2_clk_in,
    input  logic       ps2_data_in,
    output logic       ps2_clk_pull,
    output logic       ps2_data_pull,
    output logic       tx_done,
    output logic       retry_pending
);
    localparam logic [BIT_W-1:0] STOP_IDX  = BIT_W'(FRAME_LEN - 1);
    localparam logic [BIT_W-1:0] ABORT_MAX = BIT_W'(LAST_ABORT_BIT);

    tx_state_t        state;
    logic [1:0]       phase;
    logic [BIT_W-1:0] bitn;
    logic [7:0]       hold_q;
    logic             pending;
    logic             data_lvl;
    logic             done_q;
    logic             retry_q;
    logic             clk_s;
    logic             data_s;
    logic             tick;
    logic             cur_lvl;
    logic             busy;
    logic             go;
    logic             host_grab;
    logic             frame_end;

    ps2tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ps2_clk_in, ps2_data_in}),
        .q     ({clk_s, data_s})
    );

    ps2tx_qdiv #(.QTR_CYC(QTR_CYC)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ps2tx_framebits u_bits (
        .dbyte (hold_q),
        .idx   (bitn),
        .level (cur_lvl)
    );

    assign busy      = (state == ST_SEND);
    assign go        = (state == ST_IDLE) && pending && !tx_req && clk_s && data_s;
    assign host_grab = busy && (phase == PH_SETUP) && tick && !clk_s && (bitn <= ABORT_MAX);
    assign frame_end = busy && (phase == PH_LOW_B) && tick && (bitn == STOP_IDX);

    // Sequence the idle/send state, the quarter phase and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= PH_HOLD;
            bitn  <= '0;
        end else if (go) begin
            state <= ST_SEND;
            phase <= PH_HOLD;
            bitn  <= '0;
        end else if (host_grab || frame_end) begin
            state <= ST_IDLE;
            phase <= PH_HOLD;
        end else if (busy && tick) begin
            phase <= phase + 2'd1;
            if (phase == PH_LOW_B) bitn <= bitn + 1'b1;
        end
    end

    // Present the next bit one quarter after CLK is released; idle high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data_lvl <= 1'b1;
        else if (host_grab || frame_end)        data_lvl <= 1'b1;
        else if (busy && tick && phase == PH_HOLD) data_lvl <= cur_lvl;
    end

    // Capture or replace the held byte while idle; drop it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            pending <= 1'b0;
        end else if (state == ST_IDLE && tx_req) begin
            hold_q  <= tx_byte;
            pending <= 1'b1;
        end else if (frame_end) begin
            pending <= 1'b0;
        end
    end

    // Report completion as a pulse and keep the retry flag between abort and resend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (host_grab)      retry_q <= 1'b1;
            else if (frame_end) retry_q <= 1'b0;
        end
    end

    assign ps2_clk_pull  = busy && phase[1];
    assign ps2_data_pull = busy && !data_lvl;
    assign tx_done       = done_q;
    assign retry_pending = retry_q;

    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(clk_s && data_s));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps2_clk_pull |-> $stable(ps2_data_pull));

    // R7
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_pending) |-> (!ps2_clk_pull && !ps2_data_pull));

    // R9
    late_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_pending) |-> ($past(bitn) <= ABORT_MAX));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R8
    done_clears_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !retry_pending);
endmodule

// File: tb/sim_ps2_dev_tx.sv
module sim_ps2_dev_tx;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_req = 1'b0;
    logic       host_clk_hold = 1'b0;
    logic       host_data_low = 1'b0;
    logic       ps2_clk_pull, ps2_data_pull, tx_done, retry_pending;
    logic       clk_line, data_line;

    assign clk_line  = !(ps2_clk_pull || host_clk_hold);
    assign data_line = !(ps2_data_pull || host_data_low);

    always #5 clk = ~clk;

    ps2_dev_tx #(.QTR_CYC(Q), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_byte       (tx_byte),
        .tx_req        (tx_req),
        .ps2_clk_in    (clk_line),
        .ps2_data_in   (data_line),
        .ps2_clk_pull  (ps2_clk_pull),
        .ps2_data_pull (ps2_data_pull),
        .tx_done       (tx_done),
        .retry_pending (retry_pending)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int nb = 0;
    int pulses = 0;
    bit ended = 1'b0;
    logic [7:0]  exp_q[$];
    logic [10:0] fb;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: rebuild frames from the pull enables and score them on tx_done.
    logic prev_cp = 1'b0, prev_dp = 1'b0, prev_rp = 1'b0;
    int   hi_cnt = 0, lo_cnt = 0, rel_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_cp && ps2_clk_pull) begin
                if (nb > 0) chk(lo_cnt == 2*Q, "R6 released width", lo_cnt, 2*Q);
                if (nb < 11) fb[nb] = ~ps2_data_pull;
                nb++;
                pulses++;
                hi_cnt = 0;
            end
            if (prev_cp && !ps2_clk_pull) begin
                chk(hi_cnt == 2*Q, "R6 low width", hi_cnt, 2*Q);
                rel_cnt = 0;
                lo_cnt = 0;
            end
            if (ps2_data_pull != prev_dp) begin
                chk(!ps2_clk_pull && !prev_cp, "R6 data moves while CLK low", int'(ps2_clk_pull), 0);
                if (nb > 0 && retry_pending == prev_rp)
                    chk(rel_cnt == Q, "R6 data change offset", rel_cnt, Q);
            end
            if (retry_pending && !prev_rp) nb = 0;
            if (tx_done) begin
                chk(nb == 11, "R10 pulse count", nb, 11);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected frame", int'(fb[8:1]), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(fb[8:1] == e, "R5 data byte", int'(fb[8:1]), int'(e));
                    chk(fb[0] == 1'b0, "R5 start bit", int'(fb[0]), 0);
                    chk(fb[9] == ~^e, "R5 odd parity", int'(fb[9]), int'(~^e));
                    chk(fb[10] == 1'b1, "R5 stop bit", int'(fb[10]), 1);
                end
                nb = 0;
            end
            if (ps2_clk_pull) hi_cnt++; else lo_cnt++;
            rel_cnt++;
        end
        prev_cp = ps2_clk_pull;
        prev_dp = ps2_data_pull;
        prev_rp = retry_pending;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            chk(1'b0, "watchdog", cyc, 150000);
            summary();
        end
    end

    // Driver: issue a request and push the expected byte onto the scoreboard.
    task automatic send_byte(input logic [7:0] b, input bit expect_it);
        @(negedge clk);
        tx_byte = b;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        if (expect_it) exp_q.push_back(b);
    endtask

    task automatic replace_byte(input logic [7:0] b);
        void'(exp_q.pop_back());
        send_byte(b, 1'b1);
    endtask

    task automatic wait_done(input string req);
        int k;
        for (k = 0; k < 5000 && !tx_done; k++) @(negedge clk);
        chk(tx_done, req, int'(tx_done), 1);
        @(negedge clk);
    endtask

    task automatic wait_nb(input int n);
        for (int k = 0; k < 5000 && nb != n; k++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        int p0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!ps2_clk_pull && !ps2_data_pull, "R1 lines released", int'({ps2_clk_pull, ps2_data_pull}), 0);
        chk(!tx_done && !retry_pending, "R1 flags low", int'({tx_done, retry_pending}), 0);

        // R5 R10: several plain frames
        send_byte(8'hA5, 1'b1); wait_done("R10 done A5");
        send_byte(8'h00, 1'b1); wait_done("R10 done 00");
        send_byte(8'hFF, 1'b1); wait_done("R10 done FF");
        send_byte(8'h01, 1'b1); wait_done("R10 done 01");
        chk(!tx_done, "R10 single-cycle done", int'(tx_done), 0);

        // R2: inhibit holds off the frame; a later request replaces the byte
        host_clk_hold = 1'b1;
        idle(4);
        p0 = pulses;
        send_byte(8'h3C, 1'b1);
        idle(300);
        chk(pulses == p0, "R2 no start while inhibited", pulses - p0, 0);
        replace_byte(8'hC3);
        idle(50);
        host_clk_hold = 1'b0;
        wait_done("R2 done after inhibit");

        // R3 R4: host request-to-send holds off the frame
        host_data_low = 1'b1;
        idle(4);
        p0 = pulses;
        send_byte(8'h5A, 1'b1);
        idle(300);
        chk(pulses == p0, "R3 no start during request-to-send", pulses - p0, 0);
        host_data_low = 1'b0;
        wait_done("R4 done after lines idle");

        // R11: request during a frame is ignored
        send_byte(8'h81, 1'b1);
        wait_nb(4);
        send_byte(8'h7E, 1'b0);
        wait_done("R11 done 81");
        p0 = pulses;
        idle(600);
        chk(pulses == p0, "R10 no frame after completion", pulses - p0, 0);

        // R7 R8: early contention after the third pulse
        send_byte(8'h96, 1'b1);
        wait_nb(3);
        host_clk_hold = 1'b1;
        for (int k = 0; k < 200 && !retry_pending; k++) @(negedge clk);
        chk(retry_pending, "R7 retry flag set", int'(retry_pending), 1);
        chk(!ps2_clk_pull && !ps2_data_pull, "R7 lines released", int'({ps2_clk_pull, ps2_data_pull}), 0);
        idle(100);
        chk(retry_pending, "R8 flag held while waiting", int'(retry_pending), 1);
        host_clk_hold = 1'b0;
        wait_done("R8 resend completes");
        chk(!retry_pending, "R8 flag cleared", int'(retry_pending), 0);

        // R7: contention at the parity bit still aborts
        send_byte(8'h6B, 1'b1);
        wait_nb(9);
        host_clk_hold = 1'b1;
        for (int k = 0; k < 200 && !retry_pending; k++) @(negedge clk);
        chk(retry_pending, "R7 abort at parity bit", int'(retry_pending), 1);
        idle(60);
        host_clk_hold = 1'b0;
        wait_done("R8 resend after parity abort");

        // R9: contention at the stop bit is ignored
        send_byte(8'hD2, 1'b1);
        wait_nb(10);
        host_clk_hold = 1'b1;
        wait_done("R9 late contention completes");
        chk(!retry_pending, "R9 no retry flag", int'(retry_pending), 0);
        host_clk_hold = 1'b0;
        idle(100);
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        summary();
    end
endmodule